// File: doc/BRIEF.md
# Pretrigger Circular Capture Buffer

This block keeps a rolling record of an incoming sample stream in a ring of RAM. Once armed, it writes every valid sample to the next address and wraps from the top of the ring back to address zero, so the newest data always replaces the oldest. When a trigger arrives together with a valid sample, the block stores a programmed number of further samples and then freezes. The RAM then holds data from both before and after the event.

When capture is frozen, the block reports three values: the address of the last write, the address of the trigger sample (found by stepping back from the last write, modulo the depth), and how many samples at or before the trigger are actually present. The last value matters when the trigger arrives before the ring has filled once. A registered read port lets the frozen contents be unloaded. Arming again discards the capture and starts over from address zero.

Top module: `pretrig_capture`

## Requirements
- R1: After reset the block is idle. `done_o` is 0 and `pre_valid_o` is 0, and samples and triggers have no effect until the first arm.
- R2: A cycle with `arm_i` high clears `done_o` at the next edge and restarts writing at address 0 with an empty fill count. The sample offered in that cycle is not stored, and the post-trigger count is latched from `post_cnt_i` in that cycle.
- R3: While armed and not done, each cycle with `in_valid_i` high writes `in_data_i` to the current write address. The address then advances by one, wrapping from DEPTH-1 to 0, so the k-th sample after arming lands at address (k-1) mod DEPTH.
- R4: A trigger takes effect only when `trig_i` and `in_valid_i` are both high while the block is waiting for a trigger. That sample is the trigger sample. `trig_i` with `in_valid_i` low is ignored.
- R5: After the trigger sample, exactly N more valid samples are stored, where N is the latched count. `done_o` rises at the clock edge that stores the last of them, or at the edge that stores the trigger sample when N is 0.
- R6: Triggers after the trigger sample are ignored. While `done_o` is high, samples are not stored and `last_ptr_o` holds its value.
- R7: `last_ptr_o` is the address of the most recent write.
- R8: When done, `trig_ptr_o` equals (`last_ptr_o` - N) mod DEPTH, which is the address that holds the trigger sample.
- R9: When done, `pre_valid_o` equals min(samples stored since arm, DEPTH) - N. This is the number of retained samples at or before the trigger. It is 0 while not done.
- R10: A `post_cnt_i` value above DEPTH-1 is clamped to DEPTH-1, so the trigger sample is always retained.
- R11: `rd_data_o` presents the RAM word at `rd_addr_i` one clock after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| arm_i | input | 1 | Start a new capture |
| in_valid_i | input | 1 | Sample strobe |
| in_data_i | input | DW | Sample value |
| trig_i | input | 1 | Trigger event, qualified by in_valid_i |
| post_cnt_i | input | CNT_W | Samples to keep after the trigger |
| done_o | output | 1 | Capture frozen |
| last_ptr_o | output | AW | Address of the most recent write |
| trig_ptr_o | output | AW | Address of the trigger sample |
| pre_valid_o | output | CW | Retained samples at or before the trigger |
| rd_addr_i | input | AW | Read address |
| rd_data_o | output | DW | Read data, one cycle latency |

## Verification
The assertions assume that `arm_i` is a single-cycle pulse, that `post_cnt_i` is stable in the arm cycle, and that reads are only meaningful once the addressed word has been written since arming. The stimulus arms before every capture and drives `post_cnt_i` together with the arm pulse. It also compares read data only for addresses the bench knows were written. Across a sweep of post counts, including values beyond the clamp, and trigger positions both before and after the first wrap, the stimulus inserts idle cycles that carry a trigger with no valid sample. It holds the trigger high through the post phase and keeps sending samples after completion, so the ignore rules are exercised against the expected RAM contents.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_POST = 2'd2,
    ST_DONE = 2'd3
  } cap_state_e;
endpackage

// File: rtl/cap_ram.sv
module cap_ram #(
  parameter int DEPTH = 16,
  parameter int DW    = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/cap_ctrl.sv
module cap_ctrl
  import cap_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic             valid_i,
  input  logic             trig_i,
  input  logic [CNT_W-1:0] post_cnt_i,
  output logic             we_o,
  output logic [AW-1:0]    waddr_o,
  output logic [AW-1:0]    last_ptr_o,
  output logic [CW-1:0]    fill_o,
  output logic [AW-1:0]    post_n_o,
  output logic             done_o
);
  localparam logic [CNT_W-1:0] MAX_N    = CNT_W'(DEPTH - 1);
  localparam logic [AW-1:0]    TOP_ADDR = AW'(DEPTH - 1);
  localparam logic [CW-1:0]    FULL     = CW'(DEPTH);

  cap_state_e    state_q;
  logic [AW-1:0] wptr_q, last_q, n_q, remain_q;
  logic [CW-1:0] fill_q;
  logic [AW-1:0] n_clamped, wptr_nxt;
  logic          accept;

  // R10: keep the trigger sample inside the ring
  assign n_clamped = (post_cnt_i > MAX_N) ? AW'(MAX_N) : AW'(post_cnt_i);
  assign accept    = valid_i && !arm_i && (state_q == ST_PRE || state_q == ST_POST);
  assign wptr_nxt  = (wptr_q == TOP_ADDR) ? '0 : wptr_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      wptr_q   <= '0;
      last_q   <= '0;
      n_q      <= '0;
      remain_q <= '0;
      fill_q   <= '0;
    end else if (arm_i) begin
      state_q  <= ST_PRE;
      wptr_q   <= '0;
      last_q   <= '0;
      n_q      <= n_clamped;
      remain_q <= '0;
      fill_q   <= '0;
    end else if (accept) begin
      wptr_q <= wptr_nxt;
      last_q <= wptr_q;
      if (fill_q != FULL) fill_q <= fill_q + 1'b1;
      if (state_q == ST_PRE) begin
        if (trig_i) begin
          remain_q <= n_q;
          state_q  <= (n_q == '0) ? ST_DONE : ST_POST;
        end
      end else begin
        remain_q <= remain_q - 1'b1;
        if (remain_q == AW'(1)) state_q <= ST_DONE;
      end
    end
  end

  assign we_o       = accept;
  assign waddr_o    = wptr_q;
  assign last_ptr_o = last_q;
  assign fill_o     = fill_q;
  assign post_n_o   = n_q;
  assign done_o     = (state_q == ST_DONE);

  // R1
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !arm_i) |=> (state_q == ST_IDLE));
  // R2
  arm_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> (!done_o && fill_o == '0 && waddr_o == '0));
  // R7
  last_track_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |=> (last_ptr_o == $past(waddr_o)));
  // R5
  post_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_POST && !arm_i && !valid_i) |=> (state_q == ST_POST && $stable(remain_q)));
  // R6
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !arm_i) |=> (done_o && $stable(last_ptr_o) && $stable(fill_o)));
  // R9
  fill_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_o <= FULL);
endmodule

// File: rtl/cap_locate.sv
module cap_locate #(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          done_i,
  input  logic [AW-1:0] last_ptr_i,
  input  logic [AW-1:0] post_n_i,
  input  logic [CW-1:0] fill_i,
  output logic [AW-1:0] trig_ptr_o,
  output logic [CW-1:0] pre_valid_o
);
  localparam bit POW2 = ((DEPTH & (DEPTH - 1)) == 0);

  // R8: step back from the last write, modulo the depth
  generate
    if (POW2) begin : g_pow2
      assign trig_ptr_o = last_ptr_i - post_n_i;
    end else begin : g_wrap
      always_comb begin
        if (last_ptr_i >= post_n_i) trig_ptr_o = last_ptr_i - post_n_i;
        else trig_ptr_o = AW'({1'b0, last_ptr_i} + (AW+1)'(DEPTH) - {1'b0, post_n_i});
      end
    end
  endgenerate

  // R9
  assign pre_valid_o = done_i ? (fill_i - CW'(post_n_i)) : '0;

  // R8
  trig_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> (int'(trig_ptr_o) < DEPTH));
  // R9
  pre_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> (pre_valid_o != '0 && int'(pre_valid_o) + int'(post_n_i) <= DEPTH));
endmodule

// File: rtl/pretrig_capture.sv
module pretrig_capture #(
  parameter int DEPTH = 16,
  parameter int DW    = 16,
  parameter int CNT_W = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic             in_valid_i,
  input  logic [DW-1:0]    in_data_i,
  input  logic             trig_i,
  input  logic [CNT_W-1:0] post_cnt_i,
  output logic             done_o,
  output logic [AW-1:0]    last_ptr_o,
  output logic [AW-1:0]    trig_ptr_o,
  output logic [CW-1:0]    pre_valid_o,
  input  logic [AW-1:0]    rd_addr_i,
  output logic [DW-1:0]    rd_data_o
);
  logic          we;
  logic [AW-1:0] waddr, post_n;
  logic [CW-1:0] fill;

  cap_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
    .clk_i, .rst_ni, .arm_i,
    .valid_i(in_valid_i), .trig_i, .post_cnt_i,
    .we_o(we), .waddr_o(waddr), .last_ptr_o, .fill_o(fill),
    .post_n_o(post_n), .done_o
  );

  cap_locate #(.DEPTH(DEPTH)) u_locate (
    .clk_i, .rst_ni, .done_i(done_o), .last_ptr_i(last_ptr_o),
    .post_n_i(post_n), .fill_i(fill), .trig_ptr_o, .pre_valid_o
  );

  cap_ram #(.DEPTH(DEPTH), .DW(DW)) u_ram (
    .clk_i, .we_i(we), .waddr_i(waddr), .wdata_i(in_data_i),
    .raddr_i(rd_addr_i), .rdata_o(rd_data_o)
  );
endmodule

// File: tb/pretrig_capture_tb.sv
module pretrig_capture_tb;
  localparam int DEPTH = 8;
  localparam int DW    = 8;
  localparam int CNT_W = 5;
  localparam int AW    = 3;
  localparam int CW    = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic arm = 1'b0, vld = 1'b0, trg = 1'b0;
  logic [DW-1:0]    dat = '0;
  logic [CNT_W-1:0] pcnt = '0;
  logic [AW-1:0]    rd_addr = '0;
  logic             done;
  logic [AW-1:0]    last_ptr, trig_ptr;
  logic [CW-1:0]    pre_valid;
  logic [DW-1:0]    rd_data;

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  pretrig_capture #(.DEPTH(DEPTH), .DW(DW), .CNT_W(CNT_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .arm_i(arm), .in_valid_i(vld), .in_data_i(dat),
    .trig_i(trg), .post_cnt_i(pcnt), .done_o(done), .last_ptr_o(last_ptr),
    .trig_ptr_o(trig_ptr), .pre_valid_o(pre_valid), .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_arm(input int n);
    arm = 1'b1; pcnt = CNT_W'(n); vld = 1'b1; dat = 8'hEE; trg = 1'b1;
    tick();
    arm = 1'b0; vld = 1'b0; trg = 1'b0;
    chk(done == 1'b0, "R2 done cleared", int'(done), 0);
  endtask

  // t: 1-based index of trigger sample; gap inserts idle cycles carrying trig
  task automatic run(input int n, input int t, input bit gap);
    int ne, total, exp_pre, kk;
    ne    = (n > DEPTH - 1) ? DEPTH - 1 : n;
    total = t + ne;
    do_arm(n);
    for (int k = 1; k <= total; k++) begin
      if (gap && (k % 3 == 0)) begin
        vld = 1'b0; trg = 1'b1;  // R4: trigger without valid is ignored
        tick();
      end
      vld = 1'b1; dat = DW'(k); trg = (k >= t);  // R6: triggers after the first ignored
      tick();
      if (k < total) chk(done == 1'b0, "R5 early done", int'(done), 0);
    end
    vld = 1'b0; trg = 1'b0;
    exp_pre = ((total > DEPTH) ? DEPTH : total) - ne;
    chk(done == 1'b1, "R5 done after post count", int'(done), 1);
    chk(int'(last_ptr) == (total - 1) % DEPTH, "R7 last_ptr", int'(last_ptr), (total - 1) % DEPTH);
    chk(int'(trig_ptr) == (t - 1) % DEPTH, "R8 trig_ptr", int'(trig_ptr), (t - 1) % DEPTH);
    chk(int'(pre_valid) == exp_pre, "R9 pre_valid", int'(pre_valid), exp_pre);
    // R6: samples after done are dropped
    for (int k = 0; k < 2; k++) begin
      vld = 1'b1; dat = 8'hAA; trg = 1'b1;
      tick();
    end
    vld = 1'b0; trg = 1'b0;
    chk(int'(last_ptr) == (total - 1) % DEPTH, "R6 last_ptr frozen", int'(last_ptr), (total - 1) % DEPTH);
    chk(done == 1'b1, "R6 done held", int'(done), 1);
    // R3 R11: unload and compare against the expected ring contents
    for (int a = 0; a < DEPTH; a++) begin
      rd_addr = AW'(a);
      tick();
      if (a < total) begin
        kk = total - ((total - 1 - a) % DEPTH);
        chk(int'(rd_data) == (kk & 8'hFF), "R3 R11 ring data", int'(rd_data), kk & 8'hFF);
      end
    end
    if (ne != n) chk(int'(pre_valid) == exp_pre, "R10 clamp", int'(pre_valid), exp_pre);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000 && !finished) begin
        fails++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=0", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    tick(); tick();
    chk(done == 1'b0, "R1 reset done", int'(done), 0);
    chk(pre_valid == '0, "R1 reset pre_valid", int'(pre_valid), 0);
    rst_n = 1'b1;
    tick();
    // R1: samples and triggers before any arm do nothing
    for (int k = 0; k < 4; k++) begin
      vld = 1'b1; trg = 1'b1; pcnt = '0; dat = DW'(k);
      tick();
    end
    vld = 1'b0; trg = 1'b0;
    chk(done == 1'b0, "R1 idle ignores input", int'(done), 0);
    chk(pre_valid == '0, "R1 idle pre_valid", int'(pre_valid), 0);
    // R2: re-arm in the middle of a post phase restarts cleanly
    do_arm(5);
    for (int k = 1; k <= 3; k++) begin
      vld = 1'b1; dat = DW'(k); trg = (k == 2);
      tick();
    end
    vld = 1'b0; trg = 1'b0;
    chk(done == 1'b0, "R5 mid-post not done", int'(done), 0);
    run(2, 1, 1'b0);
    // sweep post counts (beyond clamp too) and trigger positions
    for (int n = 0; n <= 9; n++) begin
      run(n, 1, n[0]);
      run(n, 2, !n[0]);
      run(n, 5, n[0]);
      run(n, 8, !n[0]);
      run(n, 13, n[0]);
    end
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule